// File: doc/BRIEF.md
# Multi-Master Open-Drain Bit Engine

This block is the bit-level transmit engine of a two-wire serial bus master meant for a bus that other masters share. It paces the clock line from a divider of the system clock, splitting each bus clock period into four equal quarters. It never drives either line high. Each line has one output, and asserting that output pulls the line low. Deasserting it releases the line, and an external pull-up then raises it. The engine reads both lines back through a two-flop synchronizer. It waits whenever another device holds the clock line low. On every data bit it sends as a released 1, it compares the bus level with what it sent, so that it can detect a lost wired-AND contest.

Software, or a higher-level sequencer, issues one command at a time: a START, one byte, or a STOP. The engine answers with a one-cycle pulse at the end of every bus clock slot it generates. After a byte it reports the level read during the acknowledge clock. When it loses the bus to another master it raises a sticky flag.

Top module: `odbit_master`

## Requirements
- R1: After reset both pull outputs are deasserted, `cmd_ready` is 1, and `arb_lost` and `bit_done` are 0.
- R2: A START command (`cmd_kind` 00) pulls SDA low while SCL is released and high. It gives one `bit_done` pulse and leaves both lines held low.
- R3: A byte command (`cmd_kind` 01) shifts out `cmd_byte` MSB first, one bit per SCL high phase. SDA changes only while SCL is low. The command gives 9 `bit_done` pulses in total.
- R4: On the ninth clock of a byte, SDA is released. The bus level sampled during that clock appears on `ack_bit` after the ninth pulse: 0 means acknowledge and 1 means no acknowledge.
- R5: A STOP command (`cmd_kind` 10 or 11) raises SDA while SCL is high. It gives one `bit_done` pulse and ends with both lines released.
- R6: With DIV = CLK_HZ / (4 × SCL_HZ), every SCL low phase and every SCL high phase driven by the engine lasts at least 2 × DIV system clocks.
- R7: While another device holds SCL low after the engine has released it, no slot completes. After SCL is released, the high phase still lasts at least 2 × DIV clocks and the byte completes intact.
- R8: If a released data 1 is sampled low, `arb_lost` rises together with that bit's `bit_done` pulse, and both lines are released. The command then ends: `cmd_ready` returns and no further slot is generated.
- R9: `arb_lost` stays set until a START command is accepted, and it is clear in the cycle after that acceptance.
- R10: Data 0 bits and the acknowledge clock are not checked for arbitration, so a low bus level during them never sets `arb_lost`.
- R11: `cmd_valid` is ignored while `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when `cmd_ready` is 1 |
| cmd_kind | input | 2 | 00 START, 01 byte, 10/11 STOP |
| cmd_byte | input | DATA_W | Byte to send on a byte command |
| cmd_ready | output | 1 | Engine idle, can accept a command |
| bit_done | output | 1 | One-cycle pulse at the end of each bus clock slot |
| ack_bit | output | 1 | Level read on the acknowledge clock (0 = ACK) |
| arb_lost | output | 1 | Sticky lost-arbitration flag |
| scl_in | input | 1 | Clock line level read from the bus |
| sda_in | input | 1 | Data line level read from the bus |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bus level on the pull outputs follows the internal state one cycle later. The stretch wait and the arbitration sample see the bus two cycles late, because both go through the synchronizer.

- `bit_done`, `ack_bit` and `arb_lost` change on the clock edge that ends a slot.
- The lines settle one edge after that.
- `cmd_ready` returns on the same edge as the last `bit_done`.

The bench therefore waits for `cmd_ready` and lets two further falling edges pass before it checks line levels. It counts `bit_done` pulses, bus START/STOP edges and SCL edges, all sampled on the rising clock. Because the synchronizer stretches the high phase by a few cycles, phase lengths are checked against a minimum rather than an exact count.

// File: rtl/odb_pkg.sv
package odb_pkg;
  // Command codes presented on cmd_kind
  localparam logic [1:0] CMD_START = 2'b00;
  localparam logic [1:0] CMD_BYTE  = 2'b01;

  // Kind of bus clock slot being generated
  typedef enum logic [1:0] {
    SL_START = 2'd0,
    SL_DATA  = 2'd1,
    SL_ACK   = 2'd2,
    SL_STOP  = 2'd3
  } slot_e;
endpackage

// File: rtl/odb_sync.sv
module odb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] sh;
    // Released bus idles high, so reset to 1
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/odb_qtimer.sv
module odb_qtimer #(
  parameter int DIV = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       hold,
  output logic [1:0] q,
  output logic       slot_end
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last     = (cnt == CW'(DIV - 1));
  assign slot_end = run && !hold && last && (q == 2'd3);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!hold) begin
      if (last) begin
        cnt <= '0;
        q   <= q + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: a stretched clock freezes the quarter position
  p_stretch_freezes_r7: assert property (@(posedge clk) disable iff (rst)
    (run && hold) |=> (q == $past(q)) && (cnt == $past(cnt)));
endmodule

// File: rtl/odb_seq.sv
module odb_seq
  import odb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [1:0]        q,
  input  logic              slot_end,
  output logic              run,
  output logic              hold,
  output logic              cmd_ready,
  output logic              bit_done,
  output logic              ack_bit,
  output logic              arb_lost,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam int BW = $clog2(DATA_W + 1);

  logic              busy, owned, park, in_byte_q;
  slot_e             slot;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bitn;
  logic              scl_d, sda_d, accept, lose;

  assign accept    = cmd_valid && !busy;
  assign cmd_ready = !busy;
  assign run       = busy;
  assign hold      = busy && (slot != SL_START) && (q == 2'd2) && !scl_s;
  assign lose      = slot_end && (slot == SL_DATA) && shreg[DATA_W-1] && !sda_s;

  // Line decode per slot and quarter
  always_comb begin
    scl_d = owned;
    sda_d = owned && park;
    if (busy) begin
      unique case (slot)
        SL_START: begin scl_d = 1'b0;  sda_d = q[1]; end
        SL_DATA:  begin scl_d = !q[1]; sda_d = !shreg[DATA_W-1]; end
        SL_ACK:   begin scl_d = !q[1]; sda_d = 1'b0; end
        default:  begin scl_d = !q[1]; sda_d = (q != 2'd3); end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      owned     <= 1'b0;
      park      <= 1'b0;
      slot      <= SL_START;
      shreg     <= '0;
      bitn      <= '0;
      bit_done  <= 1'b0;
      ack_bit   <= 1'b1;
      arb_lost  <= 1'b0;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      in_byte_q <= 1'b0;
    end else begin
      bit_done  <= 1'b0;
      scl_pull  <= scl_d;
      sda_pull  <= sda_d;
      in_byte_q <= busy && (slot == SL_DATA || slot == SL_ACK);
      if (accept) begin
        busy <= 1'b1;
        if (cmd_kind == CMD_START) begin
          slot     <= SL_START;
          arb_lost <= 1'b0;
        end else if (cmd_kind == CMD_BYTE) begin
          slot  <= SL_DATA;
          shreg <= cmd_byte;
          bitn  <= '0;
        end else begin
          slot <= SL_STOP;
        end
      end else if (slot_end) begin
        bit_done <= 1'b1;
        unique case (slot)
          SL_START: begin
            owned <= 1'b1;
            park  <= 1'b1;
            busy  <= 1'b0;
          end
          SL_DATA: begin
            if (lose) begin
              arb_lost <= 1'b1;
              busy     <= 1'b0;
              owned    <= 1'b0;
              park     <= 1'b0;
            end else begin
              shreg <= shreg << 1;
              bitn  <= bitn + 1'b1;
              if (bitn == BW'(DATA_W - 1)) slot <= SL_ACK;
            end
          end
          SL_ACK: begin
            ack_bit <= sda_s;
            busy    <= 1'b0;
            park    <= 1'b0;
          end
          default: begin
            busy  <= 1'b0;
            owned <= 1'b0;
            park  <= 1'b0;
          end
        endcase
      end
    end
  end

  // R8: the losing bit leaves both lines released
  p_release_at_loss_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!scl_pull && !sda_pull));

  // R9: flag only clears through an accepted START
  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && !(accept && cmd_kind == CMD_START)) |=> arb_lost);

  // R3: slot pulses never come back to back
  p_done_isolated_r3: assert property (@(posedge clk) disable iff (rst)
    bit_done |=> !bit_done);

  // R3: inside a byte, SDA moves only with SCL pulled low
  p_sda_moves_low_scl_r3: assert property (@(posedge clk) disable iff (rst)
    (in_byte_q && $past(in_byte_q) && (sda_pull != $past(sda_pull))) |-> scl_pull);
endmodule

// File: rtl/odbit_master.sv
module odbit_master #(
  parameter int CLK_HZ = 125_000_000,
  parameter int SCL_HZ = 3_125_000,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [DATA_W-1:0] cmd_byte,
  output logic              cmd_ready,
  output logic              bit_done,
  output logic              ack_bit,
  output logic              arb_lost,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam int DIV = CLK_HZ / (4 * SCL_HZ);

  logic [1:0] line_s;
  logic [1:0] q;
  logic       run, hold, slot_end;

  odb_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (line_s)
  );

  odb_qtimer #(.DIV(DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .hold     (hold),
    .q        (q),
    .slot_end (slot_end)
  );

  odb_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_byte  (cmd_byte),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .q         (q),
    .slot_end  (slot_end),
    .run       (run),
    .hold      (hold),
    .cmd_ready (cmd_ready),
    .bit_done  (bit_done),
    .ack_bit   (ack_bit),
    .arb_lost  (arb_lost),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull)
  );
endmodule

// File: tb/odbit_master_tb_top.sv
`timescale 1ns/1ps
module odbit_master_tb_top;
  localparam int DIV = 125_000_000 / (4 * 3_125_000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [7:0] cmd_byte = 8'h00;
  logic cmd_ready, bit_done, ack_bit, arb_lost, scl_pull, sda_pull;
  logic ext_scl = 1'b0, ext_arb = 1'b0, ack_en = 1'b0, ack_drive;
  logic scl_bus, sda_bus;

  assign scl_bus = !(scl_pull || ext_scl);
  assign sda_bus = !(sda_pull || ext_arb || ack_drive);

  always #4 clk = ~clk;

  odbit_master dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .bit_done(bit_done),
    .ack_bit(ack_bit), .arb_lost(arb_lost), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  int n_chk = 0, n_fail = 0;
  int done_cnt, start_cnt, stop_cnt, rise_cnt, fall_cnt;
  int low_len, high_len, min_low, min_high;
  int mark_rise = 0, mark_fall = 0, ack_mark = 0;
  logic pscl, psda;
  logic [8:0] rx_sh;

  // Bus monitor and acknowledging receiver, sampled on the rising clock
  always @(posedge clk) begin
    if (rst) begin
      pscl <= 1'b1; psda <= 1'b1; done_cnt <= 0; start_cnt <= 0; stop_cnt <= 0;
      rise_cnt <= 0; fall_cnt <= 0; low_len <= 0; high_len <= 0;
      min_low <= 0; min_high <= 0; rx_sh <= '0; ack_drive <= 1'b0;
    end else begin
      pscl <= scl_bus; psda <= sda_bus;
      if (bit_done) done_cnt <= done_cnt + 1;
      if (pscl && scl_bus && psda && !sda_bus) start_cnt <= start_cnt + 1;
      if (pscl && scl_bus && !psda && sda_bus) stop_cnt <= stop_cnt + 1;
      if (scl_bus) high_len <= pscl ? high_len + 1 : 1;
      else         low_len  <= !pscl ? low_len + 1 : 1;
      if (!pscl && scl_bus) begin
        rise_cnt <= rise_cnt + 1;
        rx_sh    <= {rx_sh[7:0], sda_bus};
        min_low  <= (rise_cnt == mark_rise || low_len < min_low) ? low_len : min_low;
      end
      if (pscl && !scl_bus) begin
        fall_cnt <= fall_cnt + 1;
        min_high <= (fall_cnt == mark_fall || high_len < min_high) ? high_len : min_high;
      end
      if (ack_en && (rise_cnt - ack_mark == 8) && !scl_bus) ack_drive <= 1'b1;
      else if ((rise_cnt - ack_mark >= 9) && !scl_bus)      ack_drive <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [7:0] b);
    while (!cmd_ready) @(negedge clk);
    cmd_kind = kind; cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!scl_pull && !sda_pull, "R1 pulls released", {scl_pull, sda_pull}, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(!arb_lost && !bit_done, "R1 flags clear", {arb_lost, bit_done}, 0);
  endtask

  task automatic t_start();
    int d0 = done_cnt, s0 = start_cnt;
    issue(2'b00, 8'h00);
    wait_ready();
    chk(start_cnt - s0 == 1, "R2 start edge", start_cnt - s0, 1);
    chk(done_cnt - d0 == 1, "R2 one slot", done_cnt - d0, 1);
    chk(!scl_bus && !sda_bus, "R2 lines held low", {scl_bus, sda_bus}, 0);
  endtask

  task automatic t_byte(input logic [7:0] b, input bit ack, input bit poke);
    int d0 = done_cnt, s0 = start_cnt, p0 = stop_cnt;
    mark_rise = rise_cnt; mark_fall = fall_cnt; ack_mark = rise_cnt; ack_en = ack;
    issue(2'b01, b);
    if (poke) begin
      repeat (50) @(negedge clk);
      cmd_kind = 2'b00; cmd_valid = 1'b1;     // R11: must be ignored while busy
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_ready();
    chk(rx_sh[8:1] == b, "R3 byte MSB first", rx_sh[8:1], b);
    chk(done_cnt - d0 == 9, "R3 nine slots", done_cnt - d0, 9);
    chk(start_cnt == s0 && stop_cnt == p0, "R3 no SDA move with SCL high",
        start_cnt - s0 + stop_cnt - p0, 0);
    chk(rx_sh[0] == !ack, "R4 ninth clock level", rx_sh[0], !ack);
    chk(ack_bit == !ack, "R4 ack_bit", ack_bit, !ack);
    chk(min_low >= 2 * DIV, "R6 low phase", min_low, 2 * DIV);
    chk(min_high >= 2 * DIV, "R6 high phase", min_high, 2 * DIV);
    if (poke) chk(start_cnt == s0 && done_cnt - d0 == 9, "R11 busy request ignored",
                  done_cnt - d0, 9);
    ack_en = 1'b0;
  endtask

  task automatic t_stop();
    int d0 = done_cnt, p0 = stop_cnt;
    issue(2'b10, 8'h00);
    wait_ready();
    chk(stop_cnt - p0 == 1, "R5 stop edge", stop_cnt - p0, 1);
    chk(done_cnt - d0 == 1, "R5 one slot", done_cnt - d0, 1);
    chk(scl_bus && sda_bus && !scl_pull && !sda_pull, "R5 lines released",
        {scl_bus, sda_bus}, 3);
  endtask

  task automatic t_stretch(input logic [7:0] b);
    int d1;
    mark_rise = rise_cnt; mark_fall = fall_cnt; ack_mark = rise_cnt; ack_en = 1'b1;
    issue(2'b01, b);
    while (!((rise_cnt - mark_rise == 3) && !scl_bus)) @(negedge clk);
    ext_scl = 1'b1;
    d1 = done_cnt;
    repeat (6 * DIV) @(negedge clk);
    chk(done_cnt == d1, "R7 no slot ends while held", done_cnt - d1, 0);
    ext_scl = 1'b0;
    wait_ready();
    chk(rx_sh[8:1] == b, "R7 byte intact", rx_sh[8:1], b);
    chk(min_high >= 2 * DIV, "R7 full high phase", min_high, 2 * DIV);
    ack_en = 1'b0;
  endtask

  task automatic t_noarb();
    int d0 = done_cnt;
    ext_arb = 1'b1;                      // another master drives zeros
    issue(2'b01, 8'h00);
    wait_ready();
    chk(arb_lost == 1'b0, "R10 zeros and ack not checked", arb_lost, 0);
    chk(done_cnt - d0 == 9, "R10 byte completes", done_cnt - d0, 9);
    ext_arb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_arb();
    int d0 = done_cnt;
    issue(2'b01, 8'hC0);
    while (!((done_cnt - d0 == 1) && !scl_bus)) @(negedge clk);
    ext_arb = 1'b1;                      // pull low during a released 1
    wait_ready();
    chk(arb_lost == 1'b1, "R8 loss flagged", arb_lost, 1);
    chk(done_cnt - d0 == 2, "R8 loss on second bit", done_cnt - d0, 2);
    chk(!scl_pull && !sda_pull, "R8 lines released", {scl_pull, sda_pull}, 0);
    repeat (200) @(negedge clk);
    chk(done_cnt - d0 == 2 && cmd_ready, "R8 transfer abandoned", done_cnt - d0, 2);
    ext_arb = 1'b0;
    repeat (100) @(negedge clk);
    chk(arb_lost == 1'b1, "R9 flag sticky", arb_lost, 1);
    issue(2'b00, 8'h00);
    chk(arb_lost == 1'b0, "R9 cleared by start", arb_lost, 0);
    wait_ready();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_byte(8'hA5, 1'b1, 1'b1);
    t_byte(8'h3C, 1'b0, 1'b0);
    t_stop();
    t_start();
    t_stretch(8'h96);
    t_stop();
    t_start();
    t_noarb();
    t_stop();
    t_start();
    t_arb();
    t_byte(8'h5A, 1'b1, 1'b0);
    t_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule